// File: doc/BRIEF.md
# Heap Sift-Down Pop Controller

This block removes the smallest entry from a binary min-heap. The heap sits at addresses 1 through `size` of a single-port memory that reads combinationally and writes on the clock edge. The smallest value is always at address 1. On a `start` pulse the controller copies the last entry into a working register and asks an external counter to decrement the element count. It then walks down from the root. At each level it reads the left child and, if one exists, the right child. It keeps the smaller of the two, and while that child is strictly smaller than the carried value it moves the child up one level and descends. The carried value is written into the last hole and `done` pulses.

The controller uses one memory access per state, so the memory needs no second port. Its surroundings own the memory, the element counter and any sharing of the memory with an insert engine. Before issuing `start`, the caller reads the value being removed from address 1.

Top module: `heap_pop`

## Requirements
- R1: While reset is held and in the first idle cycle after it, `done`, `memWen` and `sizeDec` are all 0.
- R2: A `start` pulse while `size` is 0 has no effect: no `sizeDec`, no memory write, no `done`, and the memory and count stay unchanged.
- R3: Each accepted pop raises `sizeDec` exactly once, in the cycle right after `start`. In that cycle `memAddr` equals the count as it was before the pop, which selects the last element.
- R4: After a pop, addresses 1 to size-1 hold exactly what a sift-down produces. The old last value starts at the root. The right child replaces the left as candidate only if it is strictly smaller. The candidate moves up only if it is strictly smaller than the carried value.
- R5: Values found at address 1 before successive pops form a nondecreasing sequence.
- R6: `done` is high for exactly one cycle per pop, and that cycle carries a memory write (the final placement).
- R7: No memory write happens outside a pop operation, and no write ever targets address 0.
- R8: From the edge that samples `start` to the first cycle with `done` high takes 2 edges. Each level visited adds 2 more edges, or 3 when that level has a right child.
- R9: With the memory full (255 entries at 8 address bits), doubled child indices above 255 count as beyond the heap, and every pop still meets R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Asynchronous active-high reset |
| start | input | 1 | One-cycle request to remove the root |
| size | input | AW | Current element count from the external counter |
| memRdata | input | DW | Combinational read data at `memAddr` |
| memAddr | output | AW | Memory address for this cycle's read or write |
| memWdata | output | DW | Write data |
| memWen | output | 1 | Write enable, write on the next rising edge |
| sizeDec | output | 1 | Request to decrement the element count |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong index or a stale child register shows up as heap contents that differ from the bench's sift-down result. That difference is visible in memory one cycle after `done`, on the same pop that went wrong, and it usually breaks the ordering of the roots read on later pops as well. A wrong branch decision at a level changes the cycle count from `start` to `done`, so the bench compares latency on every pop. A full 255-entry heap drives the index arithmetic past the top address, and empty-heap requests confirm that nothing moves at the memory or counter ports.

// File: rtl/heap_pop_pkg.sv
package heap_pop_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_INIT, ST_CHILD, ST_RCOMP, ST_PCOMP, ST_DONE
  } popState_t;

  typedef enum logic [1:0] {
    ADDR_LAST, ADDR_CHILD, ADDR_RIGHT, ADDR_HOLE
  } addrSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic     loadLast;
    logic     loadChild;
    logic     tryRight;
    logic     tryDescend;
    logic     placeFinal;
    addrSel_t addrSel;
  } popCtrl_t;

  // conditions from datapath to control
  typedef struct packed {
    logic rightExists;
    logic childSmaller;
    logic deeperExists;
  } popFlags_t;

endpackage

// File: rtl/heap_pop_datapath.sv
module heap_pop_datapath
  import heap_pop_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  popCtrl_t      ctrl,
  input  logic [AW-1:0] size,
  input  logic [DW-1:0] memRdata,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memWdata,
  output logic          memWen,
  output popFlags_t     flags
);
  localparam int IW = AW + 1;  // one extra bit so index overflow compares as out of range

  logic [AW-1:0] holeIdx;
  logic [IW-1:0] childIdx;
  logic [DW-1:0] carried;
  logic [DW-1:0] bestChild;

  logic [IW-1:0] rightIdx;
  logic [IW-1:0] deeperIdx;
  logic [IW-1:0] sizeWide;
  logic          rightLess;

  assign rightIdx  = childIdx + IW'(1);
  assign deeperIdx = {childIdx[AW-1:0], 1'b0};
  assign sizeWide  = {1'b0, size};
  assign rightLess = memRdata < bestChild;

  assign flags.rightExists  = rightIdx <= sizeWide;
  assign flags.deeperExists = deeperIdx <= sizeWide;
  assign flags.childSmaller = bestChild < carried;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      holeIdx   <= '0;
      childIdx  <= '0;
      carried   <= '0;
      bestChild <= '0;
    end else begin
      if (ctrl.loadLast) begin
        carried  <= memRdata;
        holeIdx  <= AW'(1);
        childIdx <= IW'(2);
      end
      if (ctrl.loadChild) bestChild <= memRdata;
      if (ctrl.tryRight && rightLess) begin
        bestChild <= memRdata;
        childIdx  <= rightIdx;
      end
      if (ctrl.tryDescend && flags.childSmaller) begin
        holeIdx  <= childIdx[AW-1:0];
        childIdx <= deeperIdx;
      end
    end
  end

  always_comb begin
    unique case (ctrl.addrSel)
      ADDR_LAST:  memAddr = size;
      ADDR_CHILD: memAddr = childIdx[AW-1:0];
      ADDR_RIGHT: memAddr = rightIdx[AW-1:0];
      default:    memAddr = holeIdx;
    endcase
  end

  assign memWen   = (ctrl.tryDescend && flags.childSmaller) || ctrl.placeFinal;
  assign memWdata = ctrl.placeFinal ? carried : bestChild;

endmodule

// File: rtl/heap_pop_control.sv
module heap_pop_control
  import heap_pop_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] size,
  input  popFlags_t     flags,
  output popCtrl_t      ctrl,
  output logic          sizeDec,
  output logic          done
);
  popState_t state, nextState;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) state <= ST_IDLE;
    else     state <= nextState;
  end

  always_comb begin
    nextState    = state;
    ctrl         = '0;
    ctrl.addrSel = ADDR_HOLE;
    sizeDec      = 1'b0;
    done         = 1'b0;
    unique case (state)
      ST_IDLE: if (start && size != '0) nextState = ST_INIT;
      ST_INIT: begin
        ctrl.loadLast = 1'b1;
        ctrl.addrSel  = ADDR_LAST;
        sizeDec       = 1'b1;
        nextState     = (size > AW'(2)) ? ST_CHILD : ST_DONE;
      end
      ST_CHILD: begin
        ctrl.loadChild = 1'b1;
        ctrl.addrSel   = ADDR_CHILD;
        nextState      = flags.rightExists ? ST_RCOMP : ST_PCOMP;
      end
      ST_RCOMP: begin
        ctrl.tryRight = 1'b1;
        ctrl.addrSel  = ADDR_RIGHT;
        nextState     = ST_PCOMP;
      end
      ST_PCOMP: begin
        ctrl.tryDescend = 1'b1;
        nextState = (flags.childSmaller && flags.deeperExists) ? ST_CHILD : ST_DONE;
      end
      ST_DONE: begin
        ctrl.placeFinal = 1'b1;
        done            = 1'b1;
        nextState       = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/heap_pop.sv
module heap_pop
  import heap_pop_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] size,
  input  logic [DW-1:0] memRdata,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memWdata,
  output logic          memWen,
  output logic          sizeDec,
  output logic          done
);
  popCtrl_t  ctrl;
  popFlags_t flags;

  heap_pop_control #(.AW(AW)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .size(size),
    .flags(flags), .ctrl(ctrl), .sizeDec(sizeDec), .done(done)
  );

  heap_pop_datapath #(.DW(DW), .AW(AW)) u_dp (
    .clk(clk), .rst(rst), .ctrl(ctrl), .size(size), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata), .memWen(memWen), .flags(flags)
  );

endmodule

// File: rtl/heap_pop_checker.sv
module heap_pop_checker #(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic [AW-1:0] size,
  input logic [AW-1:0] memAddr,
  input logic [DW-1:0] memWdata,
  input logic          memWen,
  input logic          sizeDec,
  input logic          done
);
  // set by the decrement request, cleared by the completion pulse
  logic active;
  always_ff @(posedge clk or posedge rst) begin
    if (rst)          active <= 1'b0;
    else if (done)    active <= 1'b0;
    else if (sizeDec) active <= 1'b1;
  end

  AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (rst)
    !active |-> !memWen);  // R7
  AST_NO_ADDR_ZERO: assert property (@(posedge clk) disable iff (rst)
    memWen |-> memAddr != '0);  // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);  // R6
  AST_DONE_PLACES: assert property (@(posedge clk) disable iff (rst)
    done |-> memWen);  // R6
  AST_DEC_SINGLE: assert property (@(posedge clk) disable iff (rst)
    sizeDec |=> !sizeDec);  // R3
  AST_DONE_AFTER_DEC: assert property (@(posedge clk) disable iff (rst)
    done |-> active);  // R3
  AST_EMPTY_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (!active && !sizeDec && start && size == '0) |=> !sizeDec);  // R2

endmodule

bind heap_pop heap_pop_checker #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .start(start), .size(size), .memAddr(memAddr),
  .memWdata(memWdata), .memWen(memWen), .sizeDec(sizeDec), .done(done)
);

// File: tb/tb_heap_pop.sv
`timescale 1ns/1ps
module tb_heap_pop;
  localparam int DW = 8;
  localparam int AW = 8;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [AW-1:0] size;
  logic [DW-1:0] memRdata;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memWdata;
  logic          memWen, sizeDec, done;

  logic [DW-1:0] mem [DEPTH];
  logic          tbWe = 1'b0;
  logic [AW-1:0] tbAddr = '0;
  logic [DW-1:0] tbData = '0;
  logic          tbSizeLoad = 1'b0;
  logic [AW-1:0] tbSizeVal = '0;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;

  int shadow [DEPTH];
  int shadowSize = 0;
  int lastTop = 0;

  always #10 clk = ~clk;  // 50 MHz

  heap_pop #(.DW(DW), .AW(AW)) dut (
    .clk(clk), .rst(rst), .start(start), .size(size), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata), .memWen(memWen),
    .sizeDec(sizeDec), .done(done)
  );

  assign memRdata = mem[memAddr];

  always @(posedge clk) begin
    if (memWen)    mem[memAddr] <= memWdata;
    else if (tbWe) mem[tbAddr]  <= tbData;
  end

  always @(posedge clk or posedge rst) begin
    if (rst)             size <= '0;
    else if (tbSizeLoad) size <= tbSizeVal;
    else if (sizeDec)    size <= size - 1'b1;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      miscompares++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer than 190000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int valFor(input int pat, input int i);
    case (pat)
      0: return i % 256;
      1: return 255 - (i % 256);
      2: return (i * 37 + 11) % 256;
      default: return (i * 7) % 5;
    endcase
  endfunction

  task automatic refPush(input int v);
    int k;
    shadowSize++;
    k = shadowSize;
    while (k > 1 && v < shadow[k / 2]) begin
      shadow[k] = shadow[k / 2];
      k = k / 2;
    end
    shadow[k] = v;
  endtask

  // sift-down on the shadow array; returns expected latency (R8)
  task automatic refPop(output int lat);
    int carry, newSize, hole, kid, best;
    carry   = shadow[shadowSize];
    newSize = shadowSize - 1;
    hole    = 1;
    kid     = 2;
    lat     = 2;
    if (shadowSize > 2) begin
      while (1) begin
        best = shadow[kid];
        lat += 2;
        if (kid + 1 <= newSize) begin
          lat++;
          if (shadow[kid + 1] < best) begin
            best = shadow[kid + 1];
            kid++;
          end
        end
        if (best < carry) begin
          shadow[hole] = best;
          hole = kid;
          if (2 * kid <= newSize) kid = 2 * kid;
          else break;
        end else break;
      end
    end
    shadow[hole] = carry;
    shadowSize = newSize;
  endtask

  task automatic loadHeap(input int pat, input int n);
    shadowSize = 0;
    for (int i = 1; i <= n; i++) refPush(valFor(pat, i));
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      tbWe = 1'b1; tbAddr = AW'(i); tbData = DW'(shadow[i]);
    end
    @(negedge clk);
    tbWe = 1'b0; tbSizeLoad = 1'b1; tbSizeVal = AW'(n);
    @(negedge clk);
    tbSizeLoad = 1'b0;
    lastTop = 0;
  endtask

  task automatic doPop(input string depthTag);
    int oldSize, expLat, lat, decs, top, bad;
    oldSize = shadowSize;
    top = int'(mem[1]);
    check(top >= lastTop, "R5 root order", top, lastTop);
    lastTop = top;
    refPop(expLat);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    decs = sizeDec ? 1 : 0;
    check(sizeDec && int'(memAddr) == oldSize, "R3 decrement and last address",
          int'(memAddr), oldSize);
    while (!done && lat < 2000) begin
      @(negedge clk);
      lat++;
      if (sizeDec) decs++;
    end
    check(lat == expLat, "R8 latency", lat, expLat);
    check(decs == 1, "R3 decrement count", decs, 1);
    @(negedge clk);
    check(!done, "R6 done width", int'(done), 0);
    bad = 0;
    for (int i = 1; i <= shadowSize; i++)
      if (int'(mem[i]) != shadow[i]) bad++;
    check(bad == 0 && int'(size) == shadowSize, depthTag, bad, 0);
  endtask

  task automatic emptyPop();
    logic [DW-1:0] keep;
    int quiet;
    keep = mem[1];
    quiet = 1;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 6; i++) begin
      if (sizeDec || memWen || done) quiet = 0;
      @(negedge clk);
    end
    check(quiet == 1, "R2 empty request outputs", quiet, 1);
    check(mem[1] === keep && size == '0, "R2 empty request state", int'(size), 0);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = DW'(i);
    @(negedge clk);
    check(!done && !memWen && !sizeDec, "R1 during reset",
          int'({done, memWen, sizeDec}), 0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!done && !memWen && !sizeDec, "R1 after reset",
          int'({done, memWen, sizeDec}), 0);

    emptyPop();

    // sweep heap sizes and value patterns, popping to empty (R4)
    for (int pat = 0; pat < 4; pat++) begin
      for (int n = 1; n <= 32; n++) begin
        loadHeap(pat, n);
        for (int k = 0; k < n; k++) doPop("R4 heap contents");
      end
    end
    emptyPop();

    // full memory: index arithmetic beyond the top address (R9)
    for (int pat = 2; pat < 4; pat++) begin
      loadHeap(pat, DEPTH - 1);
      for (int k = 0; k < DEPTH - 1; k++) doPop("R9 full heap contents");
    end
    emptyPop();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule